// File: doc/BRIEF.md
# Synchronous RAM Read-Port Behaviour Wrapper

This block places a small amount of logic around a bare simple-dual-port storage array. The array has one synchronous write port and one synchronous read port. On its own, that read port has one behaviour: when a read and a write hit the same word in the same cycle, it returns the old contents. It has no reset and no defined starting value. The wrapper adds a choice of same-address collision policy, a read-output reset that is synchronous or asynchronous, a selectable priority between that reset and the read enable, and a defined value that the read output shows from power-up.

All choices are elaboration-time parameters. `COLL_MODE` picks the collision policy: 0 returns the old word, 1 returns the incoming write data, 2 leaves the result undefined. `RST_KIND` picks the reset: 0 for none, 1 for synchronous, 2 for asynchronous. `RST_OVER_EN` picks the priority: 1 lets the reset win over the enable, 0 lets it act only when the read is enabled. `RST_VAL` and `INIT_VAL` give the reset word and the power-up word. The collision bypass uses a registered selector and a registered copy of the write data. An output multiplexer then picks the array word, the forwarded word, the reset word or the power-up word. This keeps the read latency at one clock.

Top module: `rdsem_wrap`

## Requirements
- R1: With `rdEn` high, `rdRst` low and no same-address write, `rdData` shows the word stored at `rdAddr` from the rising edge after the request.
- R2: With `COLL_MODE`=1, `wrEn` and `rdEn` high and `wrAddr`==`rdAddr`, `rdData` after that edge equals `wrData` of that cycle.
- R3: With `COLL_MODE`=0 and the same collision, `rdData` after that edge equals the word stored before the write.
- R4: With `COLL_MODE`=2, the collision cycle's result is unspecified. Every later non-colliding read returns exact stored data.
- R5: With `RST_KIND`=1 and `RST_OVER_EN`=1, `rdRst` high at an edge loads `RST_VAL` into `rdData`, whatever the level of `rdEn`.
- R6: With `RST_KIND`=1 and `RST_OVER_EN`=0, `rdRst` loads `RST_VAL` only when `rdEn` is also high. With `rdEn` low, `rdData` holds.
- R7: With `rdEn` low and no reset taking effect, `rdData` keeps its previous value.
- R8: With `RST_KIND`=2, `rdData` shows `RST_VAL` as soon as `rdRst` rises, before any clock edge, and stays there while `rdRst` is high.
- R9: Before the first effective read or reset, `rdData` equals `INIT_VAL`.
- R10: A write takes place only when `wrEn` is high, at `wrAddr`. A cycle with `wrEn` low leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| wrEn | input | 1 | Write enable |
| wrAddr | input | ADDR_W | Write word address |
| wrData | input | DATA_W | Write word |
| rdEn | input | 1 | Read enable |
| rdAddr | input | ADDR_W | Read word address |
| rdRst | input | 1 | Read-output reset, synchronous or asynchronous by `RST_KIND` |
| rdData | output | DATA_W | Registered read word |

## Verification
Three instances, one for each collision policy, receive the same stimulus. A reference model predicts each output every cycle. The stimulus mixes the following patterns:
- plain reads of earlier writes;
- same-address read-with-write, which separates the old-word, new-word and skipped outcomes;
- reads alongside writes to other addresses, which show that the bypass does not fire on an address mismatch;
- idle cycles, which show the hold;
- a disabled write to a live address, which shows that storage is untouched.

The reset patterns pair `rdRst` with `rdEn` both low and high. This separates reset-over-enable from enable-over-reset. A mid-cycle rise of the asynchronous reset is checked before the next edge.

// File: rtl/rdsem_pkg.sv
package rdsem_pkg;

  localparam int COLL_RDFIRST  = 0;
  localparam int COLL_WRFIRST  = 1;
  localparam int COLL_DONTCARE = 2;

  localparam int RK_NONE  = 0;
  localparam int RK_SYNC  = 1;
  localparam int RK_ASYNC = 2;

  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_RSTV = 2'd1,
    SEL_ARR  = 2'd2,
    SEL_FWD  = 2'd3
  } selT;

  typedef struct packed {
    logic selLoad;
    selT  selNext;
    logic fwdLoad;
  } strobeT;

endpackage

// File: rtl/rdsem_core.sv
module rdsem_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] coreQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // bare read port: samples the old contents on a same-address write
  always_ff @(posedge clk) begin
    if (rdEn) coreQ <= mem[rdAddr];
  end
endmodule

// File: rtl/rdsem_ctrl.sv
module rdsem_ctrl
  import rdsem_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int COLL_MODE   = COLL_WRFIRST,
  parameter int RST_KIND    = RK_SYNC,
  parameter bit RST_OVER_EN = 1'b1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdRst,
  output strobeT            strobe
);
  logic addrHit;
  logic syncRstHit;

  assign addrHit = wrEn && rdEn && (wrAddr == rdAddr);

  generate
    if (RST_KIND == RK_SYNC) begin : g_sync
      if (RST_OVER_EN) begin : g_rstwins
        assign syncRstHit = rdRst;
      end else begin : g_enwins
        assign syncRstHit = rdRst && rdEn;
      end
    end else begin : g_nosync
      assign syncRstHit = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe = '{selLoad: 1'b0, selNext: SEL_ARR, fwdLoad: 1'b0};
    if (syncRstHit) begin
      strobe.selLoad = 1'b1;
      strobe.selNext = SEL_RSTV;
    end else if (rdEn) begin
      strobe.selLoad = 1'b1;
      if (COLL_MODE == COLL_WRFIRST && addrHit) begin
        strobe.selNext = SEL_FWD;
        strobe.fwdLoad = 1'b1;
      end else begin
        strobe.selNext = SEL_ARR;
      end
    end
  end
endmodule

// File: rtl/rdsem_datapath.sv
module rdsem_datapath
  import rdsem_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              RST_KIND = RK_SYNC,
  parameter logic [DATA_W-1:0] RST_VAL  = '0,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rdRst,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] coreQ,
  output logic [DATA_W-1:0] rdData
);
  selT               selQ = SEL_INIT;
  logic [DATA_W-1:0] fwdQ;

  generate
    if (RST_KIND == RK_ASYNC) begin : g_async
      always_ff @(posedge clk or posedge rdRst) begin
        if (rdRst)               selQ <= SEL_RSTV;
        else if (strobe.selLoad) selQ <= strobe.selNext;
      end
    end else begin : g_clocked
      always_ff @(posedge clk) begin
        if (strobe.selLoad) selQ <= strobe.selNext;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.fwdLoad) fwdQ <= wrData;
  end

  always_comb begin
    case (selQ)
      SEL_INIT: rdData = INIT_VAL;
      SEL_RSTV: rdData = RST_VAL;
      SEL_FWD:  rdData = fwdQ;
      default:  rdData = coreQ;
    endcase
  end
endmodule

// File: rtl/rdsem_wrap.sv
module rdsem_wrap
  import rdsem_pkg::*;
#(
  parameter int              DATA_W      = 16,
  parameter int              ADDR_W      = 4,
  parameter int              COLL_MODE   = COLL_WRFIRST,
  parameter int              RST_KIND    = RK_SYNC,
  parameter bit              RST_OVER_EN = 1'b1,
  parameter logic [DATA_W-1:0] RST_VAL     = 16'hBEEF,
  parameter logic [DATA_W-1:0] INIT_VAL    = 16'h1234
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdRst,
  output logic [DATA_W-1:0] rdData
);
  strobeT            strobe;
  logic [DATA_W-1:0] coreQ;

  rdsem_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_core (
    .clk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .coreQ(coreQ)
  );

  rdsem_ctrl #(
    .ADDR_W(ADDR_W), .COLL_MODE(COLL_MODE),
    .RST_KIND(RST_KIND), .RST_OVER_EN(RST_OVER_EN)
  ) i_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdRst(rdRst), .strobe(strobe)
  );

  rdsem_datapath #(
    .DATA_W(DATA_W), .RST_KIND(RST_KIND),
    .RST_VAL(RST_VAL), .INIT_VAL(INIT_VAL)
  ) i_dp (
    .clk(clk), .rdRst(rdRst), .strobe(strobe), .wrData(wrData),
    .coreQ(coreQ), .rdData(rdData)
  );
endmodule

// File: rtl/rdsem_chk.sv
module rdsem_chk
  import rdsem_pkg::*;
#(
  parameter int              DATA_W      = 16,
  parameter int              ADDR_W      = 4,
  parameter int              COLL_MODE   = COLL_WRFIRST,
  parameter int              RST_KIND    = RK_SYNC,
  parameter bit              RST_OVER_EN = 1'b1,
  parameter logic [DATA_W-1:0] RST_VAL     = '0
) (
  input logic              clk,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdRst,
  input logic [DATA_W-1:0] rdData
);
  logic asyncHit;
  logic syncWins;
  assign asyncHit = (RST_KIND == RK_ASYNC) && rdRst;
  assign syncWins = (RST_KIND == RK_SYNC) && rdRst && (RST_OVER_EN || rdEn);

  // R7: idle read port holds its output
  a_r7_hold: assert property (@(posedge clk) disable iff (asyncHit)
    (!rdEn && !syncWins) |=> $stable(rdData));

  // R2: write-first forwards the incoming word on a same-address collision
  a_r2_forward: assert property (@(posedge clk) disable iff (asyncHit)
    (COLL_MODE == COLL_WRFIRST && wrEn && rdEn && wrAddr == rdAddr && !syncWins)
      |=> rdData == $past(wrData));

  // R5: reset over enable
  a_r5_rst_over_en: assert property (@(posedge clk) disable iff (asyncHit)
    (RST_KIND == RK_SYNC && RST_OVER_EN && rdRst) |=> rdData == RST_VAL);

  // R6: enable over reset
  a_r6_en_over_rst: assert property (@(posedge clk) disable iff (asyncHit)
    (RST_KIND == RK_SYNC && !RST_OVER_EN && rdRst && rdEn) |=> rdData == RST_VAL);

  // R8: asynchronous reset value visible at every edge while held
  always @(posedge clk) begin
    if (RST_KIND == RK_ASYNC && rdRst)
      a_r8_async_val: assert (rdData == RST_VAL);
  end
endmodule

bind rdsem_wrap rdsem_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COLL_MODE(COLL_MODE),
  .RST_KIND(RST_KIND), .RST_OVER_EN(RST_OVER_EN), .RST_VAL(RST_VAL)
) i_chk (
  .clk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdRst(rdRst), .rdData(rdData)
);

// File: tb/test_rdsem_wrap.sv
`timescale 1ns/1ps
module test_rdsem_wrap;
  localparam logic [15:0] WF_RV = 16'hBEEF, WF_IV = 16'h1234;
  localparam logic [15:0] RF_RV = 16'h0F0F, RF_IV = 16'h5A5A;
  localparam logic [15:0] DC_RV = 16'hDEAD, DC_IV = 16'h0042;

  // vector: {we, wa[3:0], wd[15:0], re, ra[3:0], rst}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 4'd3, 16'h1111, 1'b0, 4'd0, 1'b0},
    {1'b1, 4'd5, 16'h2222, 1'b0, 4'd0, 1'b0},
    {1'b0, 4'd0, 16'h0000, 1'b1, 4'd3, 1'b0},
    {1'b1, 4'd3, 16'h3333, 1'b1, 4'd3, 1'b0},
    {1'b0, 4'd0, 16'h0000, 1'b1, 4'd3, 1'b0},
    {1'b0, 4'd5, 16'h9999, 1'b0, 4'd5, 1'b0},
    {1'b0, 4'd0, 16'h0000, 1'b1, 4'd5, 1'b0},
    {1'b1, 4'd6, 16'h4444, 1'b1, 4'd5, 1'b0},
    {1'b0, 4'd0, 16'h0000, 1'b1, 4'd6, 1'b0},
    {1'b1, 4'd6, 16'h5555, 1'b1, 4'd6, 1'b0},
    {1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 1'b0},
    {1'b0, 4'd0, 16'h0000, 1'b1, 4'd6, 1'b0}
  };

  logic clk = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, rdRst = 1'b0;
  logic [3:0] wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] qWf, qRf, qDc;

  int total = 0, bad = 0;
  logic [15:0] refMem [16];
  logic [15:0] expWf = WF_IV, expRf = RF_IV, expDc = DC_IV;
  bit dcValid = 1'b1;

  always #2 clk = ~clk;

  rdsem_wrap #(.COLL_MODE(1), .RST_KIND(1), .RST_OVER_EN(1'b1),
               .RST_VAL(WF_RV), .INIT_VAL(WF_IV)) i_rdsem_wrap (
    .clk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdRst(rdRst), .rdData(qWf));

  rdsem_wrap #(.COLL_MODE(0), .RST_KIND(1), .RST_OVER_EN(1'b0),
               .RST_VAL(RF_RV), .INIT_VAL(RF_IV)) i_rdsem_wrap_rf (
    .clk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdRst(rdRst), .rdData(qRf));

  rdsem_wrap #(.COLL_MODE(2), .RST_KIND(2), .RST_OVER_EN(1'b1),
               .RST_VAL(DC_RV), .INIT_VAL(DC_IV)) i_rdsem_wrap_dc (
    .clk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdRst(rdRst), .rdData(qDc));

  task automatic chk(input string tag, input string who,
                     input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, who, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] wa, input logic [15:0] wd,
                      input logic re, input logic [3:0] ra, input logic rst);
    logic coll;
    logic [15:0] old;
    string tWf, tRf, tDc;
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd; rdEn = re; rdAddr = ra; rdRst = rst;
    coll = we && re && (wa == ra);
    old  = refMem[ra];
    // write-first, reset over enable
    if (rst) begin expWf = WF_RV; tWf = "R5"; end
    else if (re) begin expWf = coll ? wd : old; tWf = coll ? "R2" : "R1,R10"; end
    else tWf = "R7";
    // read-first, enable over reset
    if (rst && re) begin expRf = RF_RV; tRf = "R6"; end
    else if (rst) tRf = "R6";
    else if (re) begin expRf = old; tRf = coll ? "R3" : "R1,R10"; end
    else tRf = "R7";
    // don't-care, asynchronous reset
    if (rst) begin expDc = DC_RV; dcValid = 1'b1; tDc = "R8"; end
    else if (re) begin
      if (coll) dcValid = 1'b0; else begin expDc = old; dcValid = 1'b1; end
      tDc = "R4";
    end else tDc = "R7";
    if (we) refMem[wa] = wd;
    @(posedge clk);
    #1;
    chk(tWf, "write-first", qWf, expWf);
    chk(tRf, "read-first", qRf, expRf);
    if (dcValid) chk(tDc, "dont-care", qDc, expDc);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    // R9: power-up words before any read
    chk("R9", "write-first", qWf, WF_IV);
    chk("R9", "read-first", qRf, RF_IV);
    chk("R9", "dont-care", qDc, DC_IV);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      step(v[26], v[25:22], v[21:6], v[5], v[4:1], v[0]);
    end

    // reset with rdEn low: R5 loads, R6 holds, R8 async loads
    step(1'b0, 4'd0, 16'h0, 1'b0, 4'd0, 1'b1);
    // reset with rdEn high: all reach reset words
    step(1'b0, 4'd0, 16'h0, 1'b1, 4'd3, 1'b1);
    // release and idle: R7 hold
    step(1'b0, 4'd0, 16'h0, 1'b0, 4'd0, 1'b0);
    // read off the reset value, then an enabled write-first hit with a wrong address
    step(1'b1, 4'd7, 16'h7777, 1'b1, 4'd5, 1'b0);
    step(1'b0, 4'd0, 16'h0, 1'b1, 4'd7, 1'b0);

    // R8: asynchronous reset shows before the next edge
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; rdRst = 1'b1;
    #1;
    chk("R8", "dont-care mid-cycle", qDc, DC_RV);
    chk("R7", "write-first before edge", qWf, 16'h7777);
    @(posedge clk); #1;
    chk("R8", "dont-care held", qDc, DC_RV);
    expDc = DC_RV; expWf = WF_RV;
    chk("R5", "write-first", qWf, WF_RV);
    chk("R6", "read-first hold", qRf, 16'h7777);
    step(1'b0, 4'd0, 16'h0, 1'b0, 4'd0, 1'b0);
    step(1'b0, 4'd0, 16'h0, 1'b1, 4'd3, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule